// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller takes up to 32 level-sensitive, active-high interrupt request lines and drives two active-low processor interrupt pins: a fast pin (`fiq_n_o`) and a normal pin (`irq_n_o`). Software sets up every source through a plain register write/read port. Each source has an enable bit, a priority level from 0 (most urgent) to 14 (least urgent), a bit that steers it to the fast pin, and a 32-bit service routine address. A separate level-mask register silences all sources that sit at a chosen level, with one write.

Among the pending normal sources, the controller picks the most urgent one. When two sources share a level, the lower source number wins. The address of the winning source is presented on `vec_addr_o` one clock after the inputs change. Software claims that winner with an acknowledge write. From then on, only sources at a strictly more urgent level can pull `irq_n_o` low again, until an end-of-service write releases the level. Fast sources are not arbitrated: any eligible one pulls `fiq_n_o` low. The register port carries only single-cycle control accesses, so it has no valid/ready handshake. Every write completes in the cycle it is presented, and reads return data combinationally.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `fiq_n_o` and `irq_n_o` are high, `vec_addr_o` is 0, and every register reads 0.
- R2: Word address 0x00+n holds the setup of source n, with enable at bit 0, fast steering at bit 1 and level at bits 11:8. Address 0x20+n holds the 32-bit address of source n. Both read back as written.
- R3: A level value above 14 written to a setup register is stored, and read back, as 14.
- R4: One clock after the inputs change, `irq_n_o` is low and `vec_addr_o` shows the address of the most urgent eligible normal source. The most urgent source has the lowest level value, and on a tie the lowest source number wins. The same address reads at 0x43. With no winner, `irq_n_o` is high and `vec_addr_o` is 0.
- R5: A source whose enable bit is 0 never affects either interrupt pin and is absent from the masked status.
- R6: Setting bit L of the level mask at 0x40 removes every source at level L from both pins and from the masked status.
- R7: `fiq_n_o` is low one clock after any enabled, unmasked, pending source steered to the fast pin is present. Such sources never take part in normal arbitration, and the in-service state does not affect them.
- R8: A write to 0x44 while `irq_n_o` is low marks the presented winner's level as in service. After that, only normal sources at a strictly lower level value may assert `irq_n_o`. A write to 0x44 while `irq_n_o` is high changes nothing.
- R9: A write to 0x45 releases the most urgent in-service level. With nothing in service, the write has no effect.
- R10: A read of 0x41 returns the raw request lines. A read of 0x42 returns the requests that are enabled and not level-masked, covering both kinds of source. Both reads return their value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC | Active-high request lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data |
| fiq_n_o | output | 1 | Fast interrupt, active low |
| irq_n_o | output | 1 | Normal interrupt, active low |
| vec_addr_o | output | VEC_W | Address of the presented winner |

## Verification
Arbitration is tried with the following patterns, each of which separates one behaviour from the others:
- A lone disabled request separates gating from arbitration.
- A single enabled request shows the basic vector path.
- Two requests tied at one level, with a less urgent third, test tie-breaking on source number against ordering by level.
- Adding a fast request shows that it lowers the fast pin without disturbing the normal winner.
- Level-mask writes show the masked level dropping out, so a less urgent source takes over.
- Acknowledge, preemption and end-of-service sequences separate strict from non-strict preemption, and show which level each release pops.
- A pseudo-random phase mixes request patterns with acknowledge, release and mask writes.

A behavioural model in the bench follows all three outputs on every clock throughout.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int ADDR_W  = 8;
  localparam int PRIO_W  = 4;
  localparam int NUM_LVL = 15;
  localparam logic [PRIO_W-1:0] PRIO_LEAST = PRIO_W'(NUM_LVL - 1);

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              to_fiq;
    logic              en;
  } src_cfg_t;

  localparam logic [ADDR_W-1:0] A_CFG   = 8'h00;
  localparam logic [ADDR_W-1:0] A_VEC   = 8'h20;
  localparam logic [ADDR_W-1:0] A_LMASK = 8'h40;
  localparam logic [ADDR_W-1:0] A_RAW   = 8'h41;
  localparam logic [ADDR_W-1:0] A_MSK   = 8'h42;
  localparam logic [ADDR_W-1:0] A_CUR   = 8'h43;
  localparam logic [ADDR_W-1:0] A_ACK   = 8'h44;
  localparam logic [ADDR_W-1:0] A_EOI   = 8'h45;
endpackage

// File: rtl/irqv_cfg_regs.sv
module irqv_cfg_regs import irqv_pkg::*; #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 32,
  parameter int DATA_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output src_cfg_t [NUM_SRC-1:0]          cfg_o,
  output logic [NUM_SRC-1:0][VEC_W-1:0]   vec_o,
  output logic [NUM_LVL-1:0]              lmask_o
);
  logic [PRIO_W-1:0] prio_in;
  assign prio_in = wdata_i[PRIO_W+7:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o   <= '0;
      vec_o   <= '0;
      lmask_o <= '0;
    end else if (wr_i) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (addr_i == A_CFG + ADDR_W'(i)) begin
          cfg_o[i].en     <= wdata_i[0];
          cfg_o[i].to_fiq <= wdata_i[1];
          cfg_o[i].prio   <= (prio_in > PRIO_LEAST) ? PRIO_LEAST : prio_in;
        end
        if (addr_i == A_VEC + ADDR_W'(i))
          vec_o[i] <= wdata_i[VEC_W-1:0];
      end
      if (addr_i == A_LMASK)
        lmask_o <= wdata_i[NUM_LVL-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NUM_SRC; i++)
        p_prio_range_r3: assert (cfg_o[i].prio <= PRIO_LEAST);
    end
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter import irqv_pkg::*; #(
  parameter int NUM_SRC = 32,
  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0]               cand_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_i,
  output logic                             vld_o,
  output logic [IDW-1:0]                   id_o,
  output logic [PRIO_W-1:0]                prio_o
);
  always_comb begin
    vld_o  = 1'b0;
    id_o   = '0;
    prio_o = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand_i[i] && prio_i[i] <= prio_o) begin
        vld_o  = 1'b1;
        id_o   = IDW'(i);
        prio_o = prio_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && vld_o) begin
      p_win_is_cand_r4: assert (cand_i[id_o]);
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cand_i[i])
          p_win_is_best_r4: assert (prio_i[i] > prio_o ||
                                    (prio_i[i] == prio_o && i >= int'(id_o)));
      end
    end
  end
endmodule

// File: rtl/irqv_svc_stack.sv
module irqv_svc_stack import irqv_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ack_i,
  input  logic                 eoi_i,
  input  logic [PRIO_W-1:0]    push_lvl_i,
  output logic                 thr_vld_o,
  output logic [PRIO_W-1:0]    thr_o,
  output logic [NUM_LVL-1:0]   busy_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_o <= '0;
    else if (ack_i)
      busy_o[push_lvl_i] <= 1'b1;
    else if (eoi_i)
      busy_o <= busy_o & (busy_o - 1'b1);
  end

  always_comb begin
    thr_o = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--)
      if (busy_o[l]) thr_o = PRIO_W'(l);
  end
  assign thr_vld_o = |busy_o;

  p_push_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> busy_o[$past(push_lvl_i)]);

  p_eoi_pops_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && (|busy_o)) |=>
      $countones(busy_o) == $past($countones(busy_o)) - 1);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl import irqv_pkg::*; #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 32,
  parameter int DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_src_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 fiq_n_o,
  output logic                 irq_n_o,
  output logic [VEC_W-1:0]     vec_addr_o
);
  localparam int IDW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  src_cfg_t [NUM_SRC-1:0]            cfg;
  logic [NUM_SRC-1:0][VEC_W-1:0]     vtab;
  logic [NUM_LVL-1:0]                lmask;
  logic [NUM_SRC-1:0]                msk, irq_cand, fiq_hit, en_all;
  logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_v;
  logic                              thr_vld;
  logic [PRIO_W-1:0]                 thr;
  logic [NUM_LVL-1:0]                busy;
  logic                              win_vld;
  logic [IDW-1:0]                    win_id;
  logic [PRIO_W-1:0]                 win_prio;
  logic                              win_vld_q;
  logic [PRIO_W-1:0]                 win_prio_q;
  logic                              ack, eoi;

  irqv_cfg_regs #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .cfg_o(cfg), .vec_o(vtab), .lmask_o(lmask));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign prio_v[g]   = cfg[g].prio;
    assign en_all[g]   = cfg[g].en;
    assign msk[g]      = irq_src_i[g] & cfg[g].en & ~lmask[cfg[g].prio];
    assign fiq_hit[g]  = msk[g] & cfg[g].to_fiq;
    assign irq_cand[g] = msk[g] & ~cfg[g].to_fiq & (~thr_vld | (cfg[g].prio < thr));
  end

  irqv_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .cand_i(irq_cand), .prio_i(prio_v),
    .vld_o(win_vld), .id_o(win_id), .prio_o(win_prio));

  assign ack = reg_wr_i && (reg_addr_i == A_ACK) && win_vld_q;
  assign eoi = reg_wr_i && (reg_addr_i == A_EOI);

  irqv_svc_stack u_svc (
    .clk(clk), .rst_n(rst_n), .ack_i(ack), .eoi_i(eoi),
    .push_lvl_i(win_prio_q), .thr_vld_o(thr_vld), .thr_o(thr), .busy_o(busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_n_o    <= 1'b1;
      irq_n_o    <= 1'b1;
      vec_addr_o <= '0;
      win_vld_q  <= 1'b0;
      win_prio_q <= '0;
    end else begin
      fiq_n_o    <= ~(|fiq_hit);
      irq_n_o    <= ~win_vld;
      vec_addr_o <= win_vld ? vtab[win_id] : '0;
      win_vld_q  <= win_vld;
      win_prio_q <= win_prio;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reg_addr_i == A_CFG + ADDR_W'(i)) begin
        reg_rdata_o[PRIO_W+7:8] = cfg[i].prio;
        reg_rdata_o[1]          = cfg[i].to_fiq;
        reg_rdata_o[0]          = cfg[i].en;
      end
      if (reg_addr_i == A_VEC + ADDR_W'(i))
        reg_rdata_o = DATA_W'(vtab[i]);
    end
    case (reg_addr_i)
      A_LMASK: reg_rdata_o = DATA_W'(lmask);
      A_RAW:   reg_rdata_o = DATA_W'(irq_src_i);
      A_MSK:   reg_rdata_o = DATA_W'(msk);
      A_CUR:   reg_rdata_o = DATA_W'(vec_addr_o);
      default: ;
    endcase
  end

  p_idle_vec_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o |-> (vec_addr_o == '0));

  p_none_enabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |=> (irq_n_o && fiq_n_o));

  p_all_levels_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&lmask) |=> (irq_n_o && fiq_n_o));

  p_busy_blocks_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_vld && thr == '0) |=> irq_n_o);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq_n, irq_n;
  logic [31:0] vec;

  int nchk = 0, nerr = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fiq_n_o(fiq_n), .irq_n_o(irq_n),
    .vec_addr_o(vec));

  // behavioural reference model
  int          m_en[32], m_fq[32], m_pr[32];
  logic [31:0] m_vec[32];
  logic [14:0] m_lmask = '0, m_busy = '0;
  logic        e_fiq = 1'b1, e_irq = 1'b1, e_wv = 1'b0;
  logic [31:0] e_vec = '0;
  int          e_wp = 0;
  int          thr, best, bid, pv;
  bit          fa;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        m_en[i] = 0; m_fq[i] = 0; m_pr[i] = 0; m_vec[i] = '0;
      end
      m_lmask = '0; m_busy = '0;
      e_fiq = 1; e_irq = 1; e_vec = '0; e_wv = 0; e_wp = 0;
    end else begin
      thr = 99;
      for (int l = 14; l >= 0; l--) if (m_busy[l]) thr = l;
      fa = 0; best = 99; bid = -1;
      for (int i = 0; i < 32; i++) begin
        if (src[i] && m_en[i] != 0 && !m_lmask[m_pr[i]]) begin
          if (m_fq[i] != 0) fa = 1;
          else if (m_pr[i] < thr && m_pr[i] < best) begin
            best = m_pr[i]; bid = i;
          end
        end
      end
      if (wr) begin
        if (addr < 8'h20) begin
          m_en[addr] = int'(wdata[0]); m_fq[addr] = int'(wdata[1]);
          pv = int'(wdata[11:8]); m_pr[addr] = (pv > 14) ? 14 : pv;
        end else if (addr < 8'h40) m_vec[addr - 8'h20] = wdata;
        else if (addr == 8'h40) m_lmask = wdata[14:0];
        else if (addr == 8'h44) begin if (e_wv) m_busy[e_wp] = 1'b1; end
        else if (addr == 8'h45) m_busy = m_busy & (m_busy - 15'd1);
      end
      e_fiq = !fa;
      e_irq = (bid < 0);
      e_vec = (bid < 0) ? '0 : m_vec[bid];
      e_wv  = (bid >= 0);
      e_wp  = (bid >= 0) ? best : 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 irq pin vs model", {31'b0, irq_n}, {31'b0, e_irq});
      chk("R4 vector vs model", vec, e_vec);
      chk("R7 fiq pin vs model", {31'b0, fiq_n}, {31'b0, e_fiq});
    end
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic set_src(logic [31:0] v); @(negedge clk); #1 src = v; endtask
  task automatic wreg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1 wr = 1; addr = a; wdata = d;
    @(negedge clk); #1 wr = 0; addr = '0;
  endtask
  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1 addr = a; #1 chk(tag, rdata, exp); addr = '0;
  endtask
  task automatic out_chk(string tag, logic exp_irq, logic exp_fiq, logic [31:0] exp_vec);
    #2;
    chk({tag, " irq_n"}, {31'b0, irq_n}, {31'b0, exp_irq});
    chk({tag, " fiq_n"}, {31'b0, fiq_n}, {31'b0, exp_fiq});
    chk({tag, " vector"}, vec, exp_vec);
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  logic [31:0] seed = 32'h1234_5678;

  initial begin
    repeat (2) @(posedge clk);
    cmp_on = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); #1 rst_n = 1;
    cyc(); out_chk("R1 reset", 1'b1, 1'b1, 32'h0);
    rd_chk(8'h03, 32'h0, "R1 setup reg");
    rd_chk(8'h40, 32'h0, "R1 level mask");
    rd_chk(8'h43, 32'h0, "R1 current vector");

    wreg(8'h03, 32'h0501);
    wreg(8'h07, 32'h0201);
    wreg(8'h0A, 32'h0201);
    wreg(8'h14, 32'h0003);
    for (int i = 0; i < 32; i++) wreg(8'h20 + 8'(i), 32'h1000 + 32'(i) * 16);
    rd_chk(8'h07, 32'h0201, "R2 setup readback");
    rd_chk(8'h27, 32'h1070, "R2 vector readback");
    wreg(8'h1E, 32'h0F00);
    rd_chk(8'h1E, 32'h0E00, "R3 level saturates");

    set_src(32'h1); cyc(); out_chk("R5 disabled source", 1'b1, 1'b1, 32'h0);
    rd_chk(8'h42, 32'h0, "R5 masked status");
    rd_chk(8'h41, 32'h1, "R10 raw status");

    set_src(32'h8); cyc(); out_chk("R4 single", 1'b0, 1'b1, 32'h1030);
    rd_chk(8'h43, 32'h1030, "R4 current vector read");
    set_src(32'h488); cyc(); out_chk("R4 tie lower number", 1'b0, 1'b1, 32'h1070);
    rd_chk(8'h42, 32'h488, "R10 masked status");
    set_src(32'h10_0488); cyc(); out_chk("R7 fast source", 1'b0, 1'b0, 32'h1070);

    wreg(8'h40, 32'h4); cyc(); out_chk("R6 level 2 masked", 1'b0, 1'b0, 32'h1030);
    rd_chk(8'h42, 32'h10_0008, "R6 masked status");
    wreg(8'h40, 32'h1); cyc(); out_chk("R6 level 0 masked", 1'b0, 1'b1, 32'h1070);
    wreg(8'h40, 32'h0); cyc();

    wreg(8'h44, 32'h0); cyc(); out_chk("R8 equal level blocked", 1'b1, 1'b0, 32'h0);
    wreg(8'h0C, 32'h0101);
    set_src(32'h10_1488); cyc(); out_chk("R8 preempt", 1'b0, 1'b0, 32'h10C0);
    wreg(8'h44, 32'h0); cyc(); out_chk("R8 nested ack", 1'b1, 1'b0, 32'h0);
    wreg(8'h45, 32'h0); cyc(); out_chk("R9 pop inner", 1'b0, 1'b0, 32'h10C0);
    set_src(32'h10_0488); cyc(); out_chk("R9 outer still busy", 1'b1, 1'b0, 32'h0);
    wreg(8'h45, 32'h0); cyc(); out_chk("R9 pop outer", 1'b0, 1'b0, 32'h1070);
    wreg(8'h45, 32'h0); cyc(); out_chk("R9 empty release ignored", 1'b0, 1'b0, 32'h1070);

    set_src(32'h0); cyc();
    wreg(8'h44, 32'h0);
    set_src(32'h8); cyc(); out_chk("R8 idle ack ignored", 1'b0, 1'b1, 32'h1030);

    for (int k = 0; k < 400; k++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      case (seed[3:0])
        4'd0:    wreg(8'h44, 32'h0);
        4'd1:    wreg(8'h45, 32'h0);
        4'd2:    wreg(8'h40, {17'b0, seed[20:6] & 15'h0AAA});
        4'd3:    wreg(8'h00 + 8'(seed[8:4]), {20'b0, seed[15:12], 6'b0, seed[10:9]});
        default: set_src(seed);
      endcase
    end
    wreg(8'h40, 32'h0);
    set_src(32'h0); cyc(); cyc();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule